// File: doc/BRIEF.md
# Two-Stage Channel Configuration Register Bank

This block is the host-facing configuration store for a multi-channel packet receiver. A host on an AXI4-Lite bus programs a few global registers and a set of per-channel filter settings. Each channel's settings are held twice. The host reads and writes a staging copy. The datapath sees a live copy. The live copy takes the staging values only while a commit bit in the control register is set. This lets software clear the bit, rewrite any number of channel settings, and then set the bit again. All the new values then reach the datapath on the same clock edge.

All channels share one address window. A channel-select register decides which channel the window reaches. The bank also provides a soft reset that clears every other register and drives an output pin. It provides a fixed version word, a channel count, and a per-channel packets-buffered count that the datapath feeds back.

The bus side is a three-state machine. IDLE accepts a write when address and data are valid together; this is the write-accept transition, and writes win over reads. Otherwise IDLE accepts a read; this is the read-accept transition. WRESP holds the write response until the host takes it, then returns to IDLE. RDATA holds the read data until the host takes it, then returns to IDLE.

Top module: `vip_cfg_regbank`

## Requirements
- R1: After reset the control register, the soft reset bit, the channel select and every staged and live channel field are 0. The version word at 0x03C reads 0x02000000 and 0x0A0 reads NUM_CH in bits [10:0].
- R2: Every accepted write gets exactly one response with bresp 2'b00, and every accepted read gets exactly one response with rresp 2'b00. bvalid, rvalid and rdata hold steady until the host asserts the matching ready.
- R3: A write changes only those bytes of the target register whose wstrb bit is 1.
- R4: The channel select at 0x030 picks the channel the window reaches. The window fields are: enable at 0x100 bit 0, filter mode at 0x110 bits [1:0], UDP port at 0x114 bits [15:0], sync source at 0x118 bits [31:0], and source address at 0x11C bits [31:0]. Window reads return the staged copy, with unused bits reading 0.
- R5: While control bit 1 (commit) is 1, each live field takes its staged value one cycle after the staged value changes. While commit is 0, the live fields hold.
- R6: Setting commit from 0 to 1 moves every staged field of every channel to the live outputs on the same edge.
- R7: Bit 0 of 0x004 is the soft reset and drives soft_reset. While it is 1, all other registers, including the live fields, are held at 0 and writes to them are lost. Writing 0 to it releases the bank.
- R8: Register 0x160 reads the packets-buffered status of the selected channel in bits [15:0]. Writes to 0x03C, 0x0A0 and 0x160 change nothing.
- R9: When the channel select is NUM_CH or more, window writes are ignored and window reads return 0. A write never changes a channel other than the selected one.
- R10: Addresses outside the map read as 0 with an OKAY response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 9 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 9 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| soft_reset | output | 1 | Soft reset bit |
| act_en | output | NUM_CH | Live enable, one bit per channel |
| act_mode | output | 2*NUM_CH | Live filter mode, channel c at [2c+1:2c] |
| act_port | output | 16*NUM_CH | Live UDP port, channel c at [16c+15:16c] |
| act_ssrc | output | 32*NUM_CH | Live sync source, channel c at [32c+31:32c] |
| act_srcip | output | 32*NUM_CH | Live source address, channel c at [32c+31:32c] |
| stat_pkts | input | 16*NUM_CH | Packets-buffered status, channel c at [16c+15:16c] |

## Verification
The assertions check the following on every cycle:
- response hold and rdata stability (R2);
- live fields hold while commit is 0 and copy staged values while it is 1 (R5);
- soft reset clears the global registers (R7);
- a write leaves every unselected channel untouched (R9);
- the version word is returned (R8).

Some behaviours only the bench scenarios can show, because they depend on the address map and on the order of operations:
- byte-strobe merging;
- the field layout and masking of the window;
- the all-at-once appearance of several staged changes when commit is raised;
- writes lost during soft reset;
- out-of-range reads returning 0.

// File: rtl/vip_cfg_pkg.sv
package vip_cfg_pkg;

    localparam int REG_AW = 9;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_CTRL = 9'h000;
    localparam logic [REG_AW-1:0] OFS_SRST = 9'h004;
    localparam logic [REG_AW-1:0] OFS_CSEL = 9'h030;
    localparam logic [REG_AW-1:0] OFS_VER  = 9'h03C;
    localparam logic [REG_AW-1:0] OFS_NCH  = 9'h0A0;
    localparam logic [REG_AW-1:0] OFS_EN   = 9'h100;
    localparam logic [REG_AW-1:0] OFS_MODE = 9'h110;
    localparam logic [REG_AW-1:0] OFS_PORT = 9'h114;
    localparam logic [REG_AW-1:0] OFS_SSRC = 9'h118;
    localparam logic [REG_AW-1:0] OFS_SIP  = 9'h11C;
    localparam logic [REG_AW-1:0] OFS_PKTS = 9'h160;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRESP = 2'd1,
        BUS_RDATA = 2'd2
    } bus_state_e;

    typedef enum logic [2:0] {
        FLD_NONE = 3'd0,
        FLD_EN   = 3'd1,
        FLD_MODE = 3'd2,
        FLD_PORT = 3'd3,
        FLD_SSRC = 3'd4,
        FLD_SIP  = 3'd5
    } fld_e;

    typedef struct packed {
        logic        en;
        logic [1:0]  mode;
        logic [15:0] port;
        logic [31:0] ssrc;
        logic [31:0] sip;
    } chan_cfg_t;

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  strb);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/vip_cfg_bus.sv
module vip_cfg_bus
    import vip_cfg_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] awaddr,
    input  logic          awvalid,
    output logic          awready,
    input  logic [DW-1:0] wdata,
    input  logic [DW/8-1:0] wstrb,
    input  logic          wvalid,
    output logic          wready,
    output logic [1:0]    bresp,
    output logic          bvalid,
    input  logic          bready,
    input  logic [AW-1:0] araddr,
    input  logic          arvalid,
    output logic          arready,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rresp,
    output logic          rvalid,
    input  logic          rready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [DW/8-1:0] wr_strb,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);

    bus_state_e state_q, state_d;
    logic [DW-1:0] rdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (awvalid && wvalid) state_d = BUS_WRESP;
                else if (arvalid)      state_d = BUS_RDATA;
            end
            BUS_WRESP: if (bready) state_d = BUS_IDLE;
            BUS_RDATA: if (rready) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        arready = 1'b0;
        bvalid  = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                awready = awvalid && wvalid;
                wready  = awvalid && wvalid;
                arready = !(awvalid && wvalid);
            end
            BUS_WRESP: bvalid = 1'b1;
            BUS_RDATA: rvalid = 1'b1;
            default: ;
        endcase
    end

    assign bresp   = 2'b00;
    assign rresp   = 2'b00;
    assign wr_en   = awready;
    assign wr_addr = awaddr;
    assign wr_data = wdata;
    assign wr_strb = wstrb;
    assign rd_en   = arready && arvalid;
    assign rd_addr = araddr;
    assign rdata   = rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_data;
    end

    p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    p_rvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
    p_single_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bvalid && rvalid));

endmodule

// File: rtl/vip_cfg_chan.sv
module vip_cfg_chan
    import vip_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  fld_e        wr_fld,
    input  logic [31:0] wdata,
    input  logic [3:0]  wstrb,
    input  logic        commit,
    output chan_cfg_t   staged,
    output chan_cfg_t   live
);

    chan_cfg_t stg_q, live_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            stg_q <= '0;
        end else begin
            unique case (wr_fld)
                FLD_EN:   if (wstrb[0]) stg_q.en <= wdata[0];
                FLD_MODE: if (wstrb[0]) stg_q.mode <= wdata[1:0];
                FLD_PORT: stg_q.port <= merge_bytes({16'h0, stg_q.port}, wdata, wstrb) >> 0;
                FLD_SSRC: stg_q.ssrc <= merge_bytes(stg_q.ssrc, wdata, wstrb);
                FLD_SIP:  stg_q.sip  <= merge_bytes(stg_q.sip, wdata, wstrb);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr)         live_q <= '0;
        else if (commit) live_q <= stg_q;
    end

    assign staged = stg_q;
    assign live   = live_q;

    p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !clr |=> live == $past(staged));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit && !clr |=> $stable(live));

endmodule

// File: rtl/vip_cfg_regbank.sv
module vip_cfg_regbank
    import vip_cfg_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter logic [31:0] VERSION = 32'h0200_0000
) (
    input  logic                  aclk,
    input  logic                  aresetn,
    input  logic [8:0]            s_awaddr,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [31:0]           s_wdata,
    input  logic [3:0]            s_wstrb,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    output logic [1:0]            s_bresp,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    input  logic [8:0]            s_araddr,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    output logic [31:0]           s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    output logic                  soft_reset,
    output logic [NUM_CH-1:0]     act_en,
    output logic [2*NUM_CH-1:0]   act_mode,
    output logic [16*NUM_CH-1:0]  act_port,
    output logic [32*NUM_CH-1:0]  act_ssrc,
    output logic [32*NUM_CH-1:0]  act_srcip,
    input  logic [16*NUM_CH-1:0]  stat_pkts
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [10:0] NCH_VAL = 11'(NUM_CH);

    logic              wr_en, rd_en;
    logic [8:0]        wr_addr, rd_addr;
    logic [31:0]       wr_data, rd_data;
    logic [3:0]        wr_strb;

    logic              soft_q, commit_q, clr;
    logic [31:0]       csel_q;
    logic              sel_ok;
    logic [IDX_W-1:0]  sel_idx;
    fld_e              fld;
    fld_e              bank_fld [NUM_CH];
    chan_cfg_t         staged [NUM_CH];
    chan_cfg_t         live   [NUM_CH];

    vip_cfg_bus #(.AW(9), .DW(32)) u_bus (
        .clk(aclk), .rst_n(aresetn),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign clr        = !aresetn || soft_q;
    assign soft_reset = soft_q;
    assign sel_ok     = (csel_q < 32'(NUM_CH));
    assign sel_idx    = csel_q[IDX_W-1:0];

    // soft reset bit: only the bus reset clears it
    always_ff @(posedge aclk) begin
        if (!aresetn)
            soft_q <= 1'b0;
        else if (wr_en && wr_addr == OFS_SRST && wr_strb[0])
            soft_q <= wr_data[0];
    end

    // global registers
    always_ff @(posedge aclk) begin
        if (clr) begin
            commit_q <= 1'b0;
            csel_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFS_CTRL && wr_strb[0]) commit_q <= wr_data[1];
            if (wr_addr == OFS_CSEL) csel_q <= merge_bytes(csel_q, wr_data, wr_strb);
        end
    end

    // window field decode
    always_comb begin
        unique case (wr_addr)
            OFS_EN:   fld = FLD_EN;
            OFS_MODE: fld = FLD_MODE;
            OFS_PORT: fld = FLD_PORT;
            OFS_SSRC: fld = FLD_SSRC;
            OFS_SIP:  fld = FLD_SIP;
            default:  fld = FLD_NONE;
        endcase
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign bank_fld[c] = (wr_en && sel_ok && sel_idx == IDX_W'(c)) ? fld : FLD_NONE;

        vip_cfg_chan u_chan (
            .clk(aclk), .rst_n(aresetn), .clr(clr),
            .wr_fld(bank_fld[c]), .wdata(wr_data), .wstrb(wr_strb),
            .commit(commit_q), .staged(staged[c]), .live(live[c])
        );

        assign act_en[c]               = live[c].en;
        assign act_mode[2*c +: 2]      = live[c].mode;
        assign act_port[16*c +: 16]    = live[c].port;
        assign act_ssrc[32*c +: 32]    = live[c].ssrc;
        assign act_srcip[32*c +: 32]   = live[c].sip;

        p_other_chan_r9: assert property (@(posedge aclk) disable iff (!aresetn)
            wr_en && !clr && csel_q != 32'(c) |=> staged[c] == $past(staged[c]));
    end

    // read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL: rd_data = {30'h0, commit_q, 1'b0};
            OFS_SRST: rd_data = {31'h0, soft_q};
            OFS_CSEL: rd_data = csel_q;
            OFS_VER:  rd_data = VERSION;
            OFS_NCH:  rd_data = {21'h0, NCH_VAL};
            OFS_EN:   if (sel_ok) rd_data = {31'h0, staged[sel_idx].en};
            OFS_MODE: if (sel_ok) rd_data = {30'h0, staged[sel_idx].mode};
            OFS_PORT: if (sel_ok) rd_data = {16'h0, staged[sel_idx].port};
            OFS_SSRC: if (sel_ok) rd_data = staged[sel_idx].ssrc;
            OFS_SIP:  if (sel_ok) rd_data = staged[sel_idx].sip;
            OFS_PKTS: if (sel_ok) rd_data = {16'h0, stat_pkts[16*sel_idx +: 16]};
            default:  rd_data = '0;
        endcase
    end

    p_soft_clear_r7: assert property (@(posedge aclk) disable iff (!aresetn)
        soft_q |=> commit_q == 1'b0 && csel_q == 32'h0);
    p_version_r8: assert property (@(posedge aclk) disable iff (!aresetn)
        rd_en && rd_addr == OFS_VER |=> s_rdata == VERSION);

endmodule

// File: tb/vip_cfg_regbank_tb.sv
module vip_cfg_regbank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic aresetn = 1'b0;
    logic [8:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid, soft_reset;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic [NCH-1:0] act_en;
    logic [2*NCH-1:0] act_mode;
    logic [16*NCH-1:0] act_port;
    logic [32*NCH-1:0] act_ssrc, act_srcip;
    logic [16*NCH-1:0] stat_pkts = '0;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vip_cfg_regbank #(.NUM_CH(NCH)) u_dut (
        .aclk(clk), .aresetn(aresetn),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .soft_reset(soft_reset), .act_en(act_en), .act_mode(act_mode),
        .act_port(act_port), .act_ssrc(act_ssrc), .act_srcip(act_srcip),
        .stat_pkts(stat_pkts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1; bready = 1'b1;
        @(posedge clk); #1;
        awvalid = 1'b0; wvalid = 1'b0;
        @(negedge clk);
        while (!bvalid) @(negedge clk);
        chk("R2 bresp", {30'h0, bresp}, 32'h0);
        @(posedge clk); #1;
        bready = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input int hold, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1; rready = 1'b0;
        @(posedge clk); #1;
        arvalid = 1'b0;
        @(negedge clk);
        chk("R2 rvalid", {31'h0, rvalid}, 32'h1);
        d = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R2 rvalid held", {31'h0, rvalid}, 32'h1);
            chk("R2 rdata held", rdata, d);
        end
        chk("R2 rresp", {30'h0, rresp}, 32'h0);
        rready = 1'b1;
        @(posedge clk); #1;
        rready = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, 0, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 soft_reset", {31'h0, soft_reset}, 32'h0);
        chk("R1 live en", {28'h0, act_en}, 32'h0);
        chk("R1 live port", act_port[31:0], 32'h0);
        rd_chk("R1 ctrl", 9'h000, 32'h0);
        rd_chk("R1 csel", 9'h030, 32'h0);
        rd_chk("R1 version", 9'h03C, 32'h0200_0000);
        rd_chk("R1 count", 9'h0A0, NCH);
        rd_chk("R1 staged ssrc", 9'h118, 32'h0);
    endtask

    task automatic t_handshake;
        logic [31:0] d;
        rd(9'h03C, 3, d);
        chk("R2 held read value", d, 32'h0200_0000);
    endtask

    task automatic t_unmapped;
        rd_chk("R10 0x008", 9'h008, 32'h0);
        rd_chk("R10 0x1FC", 9'h1FC, 32'h0);
        wr(9'h1F0, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R10 0x1F0 after write", 9'h1F0, 32'h0);
    endtask

    task automatic t_window;
        wr(9'h030, 32'd2, 4'hF);
        wr(9'h100, 32'hFFFF_FFFF, 4'hF);
        wr(9'h110, 32'hFFFF_FFFF, 4'hF);
        wr(9'h114, 32'hABCD_1234, 4'hF);
        wr(9'h11C, 32'hC0A8_0102, 4'hF);
        rd_chk("R4 enable", 9'h100, 32'h1);
        rd_chk("R4 mode", 9'h110, 32'h3);
        rd_chk("R4 port", 9'h114, 32'h1234);
        rd_chk("R4 src ip", 9'h11C, 32'hC0A8_0102);
        wr(9'h030, 32'd1, 4'hF);
        rd_chk("R4 other chan port", 9'h114, 32'h0);
        rd_chk("R4 other chan enable", 9'h100, 32'h0);
    endtask

    task automatic t_strobe;
        wr(9'h030, 32'd2, 4'hF);
        wr(9'h118, 32'h1122_3344, 4'hF);
        wr(9'h118, 32'hAABB_CCDD, 4'b0101);
        rd_chk("R3 ssrc merge", 9'h118, 32'h11BB_33DD);
        wr(9'h114, 32'h0000_5600, 4'b0010);
        rd_chk("R3 port upper byte", 9'h114, 32'h5634);
        wr(9'h000, 32'h2, 4'h0);
        rd_chk("R3 ctrl no strobe", 9'h000, 32'h0);
    endtask

    task automatic t_commit;
        // commit is 0: staged changes do not reach outputs
        @(negedge clk);
        chk("R5 live en held", {28'h0, act_en}, 32'h0);
        chk("R5 live port held", {16'h0, act_port[2*16 +: 16]}, 32'h0);
        wr(9'h030, 32'd1, 4'hF);
        wr(9'h114, 32'h0000_0777, 4'hF);
        wr(9'h100, 32'h1, 4'hF);
        @(negedge clk);
        chk("R5 ch1 port held", {16'h0, act_port[16 +: 16]}, 32'h0);
        wr(9'h000, 32'h2, 4'h1);
        @(negedge clk);
        chk("R6 ch1 port", {16'h0, act_port[16 +: 16]}, 32'h0777);
        chk("R6 ch1/ch2 enable", {28'h0, act_en}, 32'h6);
        chk("R6 ch2 mode", {30'h0, act_mode[4 +: 2]}, 32'h3);
        chk("R6 ch2 port", {16'h0, act_port[32 +: 16]}, 32'h5634);
        chk("R6 ch2 ssrc", act_ssrc[64 +: 32], 32'h11BB_33DD);
        chk("R6 ch2 src ip", act_srcip[64 +: 32], 32'hC0A8_0102);
        // live follow while commit is 1
        wr(9'h114, 32'h0000_0888, 4'hF);
        @(negedge clk);
        chk("R5 follow", {16'h0, act_port[16 +: 16]}, 32'h0888);
        // freeze again
        wr(9'h000, 32'h0, 4'h1);
        wr(9'h114, 32'h0000_0999, 4'hF);
        repeat (3) @(negedge clk);
        chk("R5 frozen", {16'h0, act_port[16 +: 16]}, 32'h0888);
        rd_chk("R5 staged differs", 9'h114, 32'h0999);
    endtask

    task automatic t_readonly;
        stat_pkts[3*16 +: 16] = 16'hBEEF;
        stat_pkts[0 +: 16]    = 16'h0101;
        wr(9'h030, 32'd3, 4'hF);
        rd_chk("R8 pkts ch3", 9'h160, 32'hBEEF);
        wr(9'h030, 32'd0, 4'hF);
        rd_chk("R8 pkts ch0", 9'h160, 32'h0101);
        wr(9'h03C, 32'h1234_5678, 4'hF);
        wr(9'h0A0, 32'h0000_0000, 4'hF);
        rd_chk("R8 version after write", 9'h03C, 32'h0200_0000);
        rd_chk("R8 count after write", 9'h0A0, NCH);
    endtask

    task automatic t_out_of_range;
        wr(9'h030, NCH, 4'hF);
        wr(9'h114, 32'h0000_4242, 4'hF);
        rd_chk("R9 window read", 9'h114, 32'h0);
        rd_chk("R9 pkts read", 9'h160, 32'h0);
        wr(9'h030, 32'd1, 4'hF);
        rd_chk("R9 ch1 unchanged", 9'h114, 32'h0999);
        wr(9'h030, 32'd2, 4'hF);
        rd_chk("R9 ch2 unchanged", 9'h114, 32'h5634);
    endtask

    task automatic t_soft_reset;
        wr(9'h000, 32'h2, 4'h1);
        wr(9'h004, 32'h1, 4'h1);
        @(negedge clk);
        chk("R7 soft_reset pin", {31'h0, soft_reset}, 32'h1);
        chk("R7 live cleared", {28'h0, act_en}, 32'h0);
        chk("R7 live ssrc cleared", act_ssrc[64 +: 32], 32'h0);
        wr(9'h030, 32'd1, 4'hF);
        rd_chk("R7 csel write lost", 9'h030, 32'h0);
        rd_chk("R7 ctrl cleared", 9'h000, 32'h0);
        wr(9'h004, 32'h0, 4'h1);
        @(negedge clk);
        chk("R7 released", {31'h0, soft_reset}, 32'h0);
        wr(9'h030, 32'd2, 4'hF);
        rd_chk("R7 ch2 staged cleared", 9'h114, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 aresetn = 1'b1;
        t_reset();
        t_handshake();
        t_unmapped();
        t_window();
        t_strobe();
        t_commit();
        t_readonly();
        t_out_of_range();
        t_soft_reset();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule